// File: doc/BRIEF.md
# Strobed Byte-Wide Frame Buffer Write Loader

This block is the host-side write port of a video frame buffer. A host that has only an 8-bit general-purpose parallel port and one strobe line builds a complete memory write over three strobed transfers. The first transfer carries the upper address byte, the second carries the lower address byte, and the third carries the pixel data. The finished write is then held in a buffer and offered to the frame buffer arbiter through a request/acknowledge pair. The arbiter takes the write in a free slot between display fetches, so the host is never stalled by the display.

The strobe line is asynchronous to the video clock. It is synchronized, and only its rising edge is used, so each strobe pulse loads at most one byte however long it is held. A busy flag rises when the data byte is taken and falls once the arbiter acknowledges the write. While busy is high, strobes are discarded. The host polls busy before it starts the next three-byte sequence.

Top module: `fb_host_loader`

## Requirements
- R1: After reset, busy and wrReq are 0, wrAddr and wrData are 0, and the next accepted strobe is treated as the upper address byte.
- R2: An accepted strobe in the upper-address phase copies hostByte into wrAddr[15:8]. The new value is visible after the third rising clock edge that sees the strobe high, and not before.
- R3: The next accepted strobe copies hostByte into wrAddr[7:0] and leaves wrAddr[15:8] unchanged.
- R4: The third accepted strobe copies hostByte into wrData and raises busy and wrReq in the same cycle.
- R5: While busy is high, wrAddr and wrData hold steady and busy stays high until wrAck is sampled high. After that edge, busy and wrReq are 0.
- R6: Strobes that arrive while busy is high change neither wrAddr, nor wrData, nor the phase. The first strobe accepted after the acknowledge loads the upper address byte.
- R7: A strobe held high for many cycles loads exactly one byte.
- R8: Changes on hostByte without a strobe edge have no effect on wrAddr or wrData.
- R9: wrAck sampled while busy is 0 has no effect. A sequence in progress continues, and busy still rises on its data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Video clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostByte | input | 8 | Shared byte from the host parallel port |
| hostStrobe | input | 1 | Asynchronous host strobe, rising edge active |
| busy | output | 1 | A buffered write is pending; new strobes are ignored |
| wrReq | output | 1 | Write request toward the frame buffer arbiter |
| wrAddr | output | 16 | Buffered write address |
| wrData | output | 8 | Buffered write data |
| wrAck | input | 1 | Arbiter has taken the buffered write |

## Verification
A wrong phase value shows on the very next strobe: the byte lands in the wrong address half or in the data register. Busy then rises one byte too early or too late, which the host sees three clocks after that strobe. A lost or doubled edge from the synchronizer shows up the same way: after a long strobe pulse, busy rises at the wrong point in the sequence. Poor busy gating shows within one strobe while a write is pending, as a change on wrAddr or wrData, or as a data byte landing in the wrong register after the acknowledge.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
  typedef enum logic [1:0] {
    PH_HI   = 2'd0,
    PH_LO   = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef struct packed {
    logic ldHi;
    logic ldLo;
    logic ldData;
  } load_t;
endpackage

// File: rtl/fbl_strobe_sync.sv
module fbl_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic strobeAsync,
  output logic strobeEdge
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN-2:0], strobeAsync};
  end

  assign strobeEdge = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

  // R7: an edge pulse lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobeEdge |=> !strobeEdge);
endmodule

// File: rtl/fbl_ctrl.sv
module fbl_ctrl
  import fbl_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  strobeEdge,
  input  logic  wrAck,
  output load_t load,
  output logic  busy
);
  phase_e phase;
  logic   accept;

  assign accept = strobeEdge && !busy;

  always_comb begin
    load        = '0;
    load.ldHi   = accept && (phase == PH_HI);
    load.ldLo   = accept && (phase == PH_LO);
    load.ldData = accept && (phase == PH_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_HI;
    end else if (accept) begin
      unique case (phase)
        PH_HI:   phase <= PH_LO;
        PH_LO:   phase <= PH_DATA;
        default: phase <= PH_HI;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            busy <= 1'b0;
    else if (load.ldData) busy <= 1'b1;
    else if (wrAck)       busy <= 1'b0;
  end

  a_r7_one_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(load));
  a_r4_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    load.ldData |=> busy);
  a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy && !wrAck |=> busy);
  a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rstN)
    busy && wrAck |=> !busy);
  a_r6_phase_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(phase));
  a_r9_idle_ack: assert property (@(posedge clk) disable iff (!rstN)
    !busy && wrAck && !load.ldData |=> !busy);
endmodule

// File: rtl/fbl_datapath.sv
module fbl_datapath
  import fbl_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  load_t               load,
  input  logic                busy,
  input  logic [BYTE_W-1:0]   hostByte,
  output logic [2*BYTE_W-1:0] wrAddr,
  output logic [DATA_W-1:0]   wrData
);
  logic [BYTE_W-1:0] addrHi;
  logic [BYTE_W-1:0] addrLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHi <= '0;
      addrLo <= '0;
      wrData <= '0;
    end else begin
      if (load.ldHi)   addrHi <= hostByte;
      if (load.ldLo)   addrLo <= hostByte;
      if (load.ldData) wrData <= DATA_W'(hostByte);
    end
  end

  assign wrAddr = {addrHi, addrLo};

  a_r2_hi_capture: assert property (@(posedge clk) disable iff (!rstN)
    load.ldHi |=> wrAddr[2*BYTE_W-1:BYTE_W] == $past(hostByte));
  a_r3_lo_capture: assert property (@(posedge clk) disable iff (!rstN)
    load.ldLo |=> wrAddr[BYTE_W-1:0] == $past(hostByte)
                  && $stable(wrAddr[2*BYTE_W-1:BYTE_W]));
  a_r5_hold_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(wrAddr) && $stable(wrData));
  a_r8_no_load_no_change: assert property (@(posedge clk) disable iff (!rstN)
    !(load.ldHi || load.ldLo || load.ldData) |=> $stable(wrAddr) && $stable(wrData));
endmodule

// File: rtl/fb_host_loader.sv
module fb_host_loader
  import fbl_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BYTE_W-1:0]   hostByte,
  input  logic                hostStrobe,
  output logic                busy,
  output logic                wrReq,
  output logic [2*BYTE_W-1:0] wrAddr,
  output logic [BYTE_W-1:0]   wrData,
  input  logic                wrAck
);
  logic  strobeEdge;
  load_t load;
  logic  busyInt;

  fbl_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .strobeAsync(hostStrobe), .strobeEdge(strobeEdge)
  );

  fbl_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .strobeEdge(strobeEdge), .wrAck(wrAck),
    .load(load), .busy(busyInt)
  );

  fbl_datapath #(.BYTE_W(BYTE_W), .DATA_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .load(load), .busy(busyInt),
    .hostByte(hostByte), .wrAddr(wrAddr), .wrData(wrData)
  );

  assign busy  = busyInt;
  assign wrReq = busyInt;

  // R1: nothing requested in the first cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> !wrReq && wrAddr == '0 && wrData == '0);
endmodule

// File: tb/test_fb_host_loader.sv
module test_fb_host_loader;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  hostByte;
  logic        hostStrobe;
  logic        busy, wrReq, wrAck;
  logic [15:0] wrAddr;
  logic [7:0]  wrData;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fb_host_loader i_fb_host_loader (
    .clk(clk), .rstN(rstN), .hostByte(hostByte), .hostStrobe(hostStrobe),
    .busy(busy), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrAck(wrAck)
  );

  // upper address, lower address, data
  localparam logic [23:0] VEC [4] = '{
    24'h12_34_56, 24'hFF_00_A5, 24'h00_FF_5A, 24'h80_01_00
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic pulse(input logic [7:0] b, input int width);
    @(negedge clk);
    hostByte   = b;
    hostStrobe = 1'b1;
    repeat (width) @(negedge clk);
    hostStrobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic ackWrite();
    @(negedge clk);
    wrAck = 1'b1;
    @(negedge clk);
    wrAck = 1'b0;
    chk("R5 busy low after ack", busy, 0);
    chk("R5 wrReq low after ack", wrReq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    rstN = 1'b0; hostByte = 8'h00; hostStrobe = 1'b0; wrAck = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 wrReq", wrReq, 0);
    chk("R1 wrAddr", wrAddr, 0);
    chk("R1 wrData", wrData, 0);

    // R2 latency: value appears after the third edge that sees the strobe
    @(negedge clk);
    hostByte = 8'hC3; hostStrobe = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 not before third edge", wrAddr[15:8], 8'h00);
    @(negedge clk);
    chk("R2 upper byte after third edge", wrAddr[15:8], 8'hC3);
    hostStrobe = 1'b0;
    repeat (4) @(negedge clk);
    pulse(8'h3C, 1);
    chk("R3 lower byte", wrAddr, 16'hC33C);
    pulse(8'h99, 1);
    chk("R4 data", wrData, 8'h99);
    chk("R4 busy", busy, 1);
    ackWrite();

    // table of full writes, ack delay grows with the index
    for (int i = 0; i < 4; i++) begin
      pulse(VEC[i][23:16], 1);
      chk("R2 upper byte", wrAddr[15:8], VEC[i][23:16]);
      pulse(VEC[i][15:8], 2);
      chk("R3 lower byte", wrAddr, VEC[i][23:8]);
      chk("R4 busy still low before data", busy, 0);
      pulse(VEC[i][7:0], 1);
      chk("R4 data", wrData, VEC[i][7:0]);
      chk("R4 busy", busy, 1);
      chk("R4 wrReq", wrReq, 1);
      repeat (i * 3) @(negedge clk);
      chk("R5 busy held", busy, 1);
      chk("R5 addr held", wrAddr, VEC[i][23:8]);
      ackWrite();
    end

    // R6: strobes while busy are dropped, phase stays at upper byte
    pulse(8'h11, 1);
    pulse(8'h22, 1);
    pulse(8'h33, 1);
    pulse(8'hEE, 1);
    pulse(8'hDD, 1);
    chk("R6 addr unchanged while busy", wrAddr, 16'h1122);
    chk("R6 data unchanged while busy", wrData, 8'h33);
    ackWrite();
    pulse(8'h44, 1);
    chk("R6 next strobe loads upper byte", wrAddr, 16'h4422);
    chk("R6 busy not raised", busy, 0);

    // R7: a long strobe loads one byte only
    pulse(8'h55, 12);
    chk("R7 long strobe one byte", wrAddr, 16'h4455);
    chk("R7 busy not raised by long strobe", busy, 0);

    // R8: data changes without a strobe do nothing
    @(negedge clk);
    hostByte = 8'hAA;
    repeat (6) @(negedge clk);
    chk("R8 addr unchanged", wrAddr, 16'h4455);
    chk("R8 data unchanged", wrData, 8'h33);
    pulse(8'h66, 1);
    chk("R8 then data strobe", wrData, 8'h66);
    ackWrite();

    // R9: ack while idle is ignored mid-sequence
    pulse(8'h01, 1);
    @(negedge clk); wrAck = 1'b1;
    repeat (3) @(negedge clk); wrAck = 1'b0;
    chk("R9 idle ack keeps busy low", busy, 0);
    pulse(8'h02, 1);
    pulse(8'h03, 1);
    chk("R9 sequence continued addr", wrAddr, 16'h0102);
    chk("R9 busy raised on data", busy, 1);
    ackWrite();

    report();
  end
endmodule